// File: doc/BRIEF.md
# Glitch-Free Clock Pulse Gate

This block lets whole pulses of one clock through to its output, or holds them back, under the control of an active-high enable. The output never carries a pulse that has been cut short. The enable is looked at only while the clock is in its inactive phase. It is then held fixed for the whole active phase, so the output is either an exact copy of the input pulse or stays at its idle level.

A build-time parameter picks one of two variants. The rising variant idles low and passes high pulses. The falling variant idles high and passes low pulses. In both variants the enable is active high. A synchronous active-high reset closes the gate, and the output then stops toggling until the reset is released. The block sits in front of a clock load so that the load can be parked without risking a runt edge.

Top module: `clock_pulse_gate`

## Requirements
- R1: Rising variant (EDGE = EDGE_RISE, the default). When `en` is 1 at the rising edge of `clk_in`, the next high phase of `clk_out` matches the input high phase exactly. It starts at that edge and lasts the full input high time, with no shorter pulse.
- R2: Rising variant. When `en` is 0 at the rising edge of `clk_in`, `clk_out` stays 0 for that whole pulse.
- R3: A change of `en` during the active phase of `clk_in` has no effect on the pulse in progress. This is the high phase for the rising variant and the low phase for the falling variant. The new value applies only from the next active edge.
- R4: Falling variant (EDGE = EDGE_FALL). `clk_out` idles at 1. When `en` is 1 at a falling edge of `clk_in`, the following input low phase is copied onto `clk_out` at full width. When `en` is 0, `clk_out` stays 1.
- R5: While the gate is closed, `clk_out` does not toggle at all. In the rising variant it stays at 0 and in the falling variant at 1.
- R6: When `rst` is 1 at an active edge, the pulse that follows is suppressed whatever `en` is. Gating resumes normally from the first active edge at which `rst` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Clock to be gated |
| rst | input | 1 | Active-high reset, closes the gate |
| en | input | 1 | Active-high pulse enable, sampled before each active edge |
| clk_out | output | 1 | Gated clock |

## Verification
On every active edge the assertions check that the held enable stays frozen through the active phase. They check that the output in that phase equals the enable and reset state taken at the edge, and that the output sits at its idle level just before each active edge. The bench's scenarios are needed to show exact pulse widths, a complete absence of output edges over a long disabled stretch, and the recovery after a reset. The bench also drives enable changes in the middle of an active phase for both variants side by side.

// File: rtl/cpg_pkg.sv
`timescale 1ns/1ps
package cpg_pkg;
  typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_e;
endpackage

// File: rtl/cpg_hold_latch.sv
`timescale 1ns/1ps
// Level-sensitive enable holder: open only in the inactive clock phase.
module cpg_hold_latch #(
  parameter cpg_pkg::edge_e EDGE = cpg_pkg::EDGE_RISE
) (
  input  logic clk_in,
  input  logic rst,
  input  logic en,
  output logic en_held
);
  localparam bit ACT_RISE = (EDGE == cpg_pkg::EDGE_RISE);

  logic act_clk;
  logic en_d;

  assign act_clk = ACT_RISE ? clk_in : ~clk_in;
  assign en_d    = en & ~rst;

  always_latch begin
    if (!act_clk) en_held = en_d;
  end

  // checker state: value held at the active edge
  logic hold_cap;
  logic armed;
  always_ff @(posedge act_clk) begin
    if (rst) begin
      armed    <= 1'b0;
      hold_cap <= 1'b0;
    end else begin
      armed    <= 1'b1;
      hold_cap <= en_held;
    end
  end

  // R3: held enable is frozen throughout the active phase
  a_r3_hold_frozen: assert property (@(negedge act_clk) disable iff (rst || !armed)
    en_held == hold_cap)
    else $error("a_r3_hold_frozen");
endmodule

// File: rtl/cpg_gate_out.sv
`timescale 1ns/1ps
// Combines the held enable with the clock; the variant fixes the idle level.
module cpg_gate_out #(
  parameter cpg_pkg::edge_e EDGE = cpg_pkg::EDGE_RISE
) (
  input  logic clk_in,
  input  logic en_held,
  output logic clk_out
);
  generate
    if (EDGE == cpg_pkg::EDGE_RISE) begin : g_and
      assign clk_out = clk_in & en_held;
    end else begin : g_or
      assign clk_out = clk_in | ~en_held;
    end
  endgenerate
endmodule

// File: rtl/clock_pulse_gate.sv
`timescale 1ns/1ps
module clock_pulse_gate #(
  parameter cpg_pkg::edge_e EDGE = cpg_pkg::EDGE_RISE
) (
  input  logic clk_in,
  input  logic rst,
  input  logic en,
  output logic clk_out
);
  localparam bit ACT_RISE = (EDGE == cpg_pkg::EDGE_RISE);

  logic en_held;

  cpg_hold_latch #(.EDGE(EDGE)) u_latch (
    .clk_in (clk_in),
    .rst    (rst),
    .en     (en),
    .en_held(en_held)
  );

  cpg_gate_out #(.EDGE(EDGE)) u_gate (
    .clk_in (clk_in),
    .en_held(en_held),
    .clk_out(clk_out)
  );

  // checker: normalise to "active-high" view of both variants
  logic act_clk;
  logic out_act;
  logic en_cap;
  logic armed;
  assign act_clk = ACT_RISE ? clk_in  : ~clk_in;
  assign out_act = ACT_RISE ? clk_out : ~clk_out;

  always_ff @(posedge act_clk) begin
    if (rst) begin
      armed  <= 1'b0;
      en_cap <= 1'b0;
    end else begin
      armed  <= 1'b1;
      en_cap <= en;
    end
  end

  // R1 / R4: enabled edge -> pulse present through the active phase
  a_r1_pulse_passes: assert property (@(negedge act_clk) disable iff (rst || !armed)
    en_cap |-> out_act)
    else $error("a_r1_pulse_passes");

  // R2 / R4: disabled edge -> pulse suppressed
  a_r2_pulse_blocked: assert property (@(negedge act_clk) disable iff (rst || !armed)
    !en_cap |-> !out_act)
    else $error("a_r2_pulse_blocked");

  // R5: idle level just before every active edge
  a_r5_idle_level: assert property (@(posedge act_clk) disable iff (rst || !armed)
    !out_act)
    else $error("a_r5_idle_level");
endmodule

// File: tb/sim_clock_pulse_gate.sv
`timescale 1ns/1ps
module sim_clock_pulse_gate;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en  = 1'b1;
  logic out_r, out_f;

  int checks = 0;
  int failures = 0;
  bit chk_on = 1'b0;
  bit finished = 1'b0;
  string tag = "R6";

  always #2.5 clk = ~clk;   // 200 MHz

  clock_pulse_gate #(.EDGE(cpg_pkg::EDGE_RISE)) u0 (
    .clk_in(clk), .rst(rst), .en(en), .clk_out(out_r));
  clock_pulse_gate #(.EDGE(cpg_pkg::EDGE_FALL)) u1 (
    .clk_in(clk), .rst(rst), .en(en), .clk_out(out_f));

  // behavioural reference: decision taken at each active edge
  bit exp_r = 1'b0;
  bit exp_f = 1'b0;
  always @(posedge clk) exp_r <= en & ~rst;
  always @(negedge clk) exp_f <= en & ~rst;

  task automatic check(input string req, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s at %0t: actual=%b expected=%b", req, $time, act, expv);
    end
  endtask

  // compare in the middle of every half cycle
  always @(posedge clk) begin
    #1;
    if (chk_on) begin
      check(tag,  out_r, exp_r);   // rising variant active phase
      check("R4", out_f, 1'b1);    // falling variant idle phase
    end
  end
  always @(negedge clk) begin
    #1;
    if (chk_on) begin
      check("R5", out_r, 1'b0);    // rising variant idle phase
      check("R4", out_f, ~exp_f);  // falling variant active phase
    end
  end

  // pulse width monitors (R1, R4)
  realtime t_r, t_f;
  always @(posedge out_r) t_r = $realtime;
  always @(negedge out_r) if (chk_on) begin
    checks++;
    if ($realtime - t_r != 2.5) begin
      failures++;
      $display("FAIL R1 width: actual=%0t expected=2.5ns", $realtime - t_r);
    end
  end
  always @(negedge out_f) t_f = $realtime;
  always @(posedge out_f) if (chk_on && t_f > 0) begin
    checks++;
    if ($realtime - t_f != 2.5) begin
      failures++;
      $display("FAIL R4 width: actual=%0t expected=2.5ns", $realtime - t_f);
    end
  end

  // edge counters for R5
  int edges_r = 0, edges_f = 0;
  always @(out_r) edges_r++;
  always @(out_f) edges_f++;

  task automatic drive_idle(input logic v);   // change in the low phase
    @(negedge clk); #1 en = v;
  endtask
  task automatic drive_active(input logic v); // change in the high phase
    @(posedge clk); #1.5 en = v;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    // R6: reset holds the gate closed although en=1
    tag = "R6";
    #3 chk_on = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); #1 rst = 1'b0;

    // R1 / R2: patterns applied in the inactive phase
    tag = "R1";
    drive_idle(1); drive_idle(1); drive_idle(0);
    tag = "R2";
    drive_idle(0); drive_idle(1); drive_idle(0); drive_idle(1); drive_idle(1);

    // R3: enable flips in the middle of the rising variant's high phase
    tag = "R3";
    drive_active(0); drive_active(1); drive_active(0); drive_active(0);
    drive_active(1); drive_active(1); drive_active(0); drive_active(1);
    drive_idle(1);

    // R5: long disabled window, no output edges at all
    tag = "R5";
    drive_idle(0);
    @(posedge clk); #1;
    edges_r = 0; edges_f = 0;
    repeat (10) @(posedge clk);
    #1;
    checks++;
    if (edges_r != 0) begin
      failures++;
      $display("FAIL R5 rising edges: actual=%0d expected=0", edges_r);
    end
    checks++;
    if (edges_f != 0) begin
      failures++;
      $display("FAIL R5 falling edges: actual=%0d expected=0", edges_f);
    end

    // R6: reset in mid-run, then recovery
    tag = "R6";
    drive_idle(1);
    drive_idle(1);
    @(negedge clk); #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst = 1'b0;
    repeat (3) @(posedge clk);
    tag = "R1";
    drive_idle(0); drive_idle(1);
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end
endmodule